// File: doc/BRIEF.md
# Funnel Shift and Rotate Unit

This block is a purely combinational N-bit shifter, with N a power of two. A 3-bit operation code selects one of six operations on the operand `a` by `k` positions, where `k` runs from 0 to N-1. The operations are logical, arithmetic and rotate shifts, each to the left or to the right. The block is meant to sit inside a datapath and has no clock or storage. Its result follows its inputs within the same cycle.

Every operation goes through the same right-only window selector. A front stage lays `a` out in a (2N-1)-bit funnel word. The fill bits of that word depend on the operation. The front stage also chooses a window offset. For right operations the offset is `k`. For left operations it is the bitwise inverse of `k`, which equals N-1-k, so no subtracter is needed. The selector then takes the N-bit window that starts at the offset. It uses log2(N) ranks of 2:1 multiplexers.

The operation code is `{dir, kind}`. `dir` (bit 2) is 0 for right and 1 for left. `kind` (bits 1:0) is 00 for logical, 01 for arithmetic, 10 for rotate and 11 for none.

Top module: `fsh_funnel`

## Requirements
- R1: With op = 000 (logical right), y equals a shifted right by k, with zeros filling the top k bits.
- R2: With op = 001 (arithmetic right), y equals a shifted right by k, with copies of a[N-1] filling the top k bits.
- R3: With op = 010 (rotate right), bit i of y equals a[(i+k) mod N].
- R4: With op = 100 (logical left), y equals a shifted left by k, with zeros filling the low k bits.
- R5: With op = 101 (arithmetic left), y is identical to the logical left result.
- R6: With op = 110 (rotate left), bit i of y equals a[(i-k) mod N].
- R7: The codes 011 and 111 return a unchanged for every k.
- R8: With k = 0, every operation returns a unchanged.
- R9: With N = 4, a = 1011 and k = 1, the six operations give these results: logical right 0101, logical left 0110, arithmetic right 1101, arithmetic left 0110, rotate right 1101, rotate left 0111.
- R10: The result depends only on the present inputs: y is valid in the same cycle that a, k and op are applied, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Operand |
| k | input | log2(N) | Shift or rotate amount |
| op | input | 3 | {dir, kind} operation code |
| y | output | N | Shifted or rotated result |

## Verification
Every result is due with zero cycles of latency, because the path from `a`, `k` and `op` to `y` has no register. The bench changes the inputs just after a rising edge. It compares `y` on the following falling edge, half a period later, so that no edge ordering affects a check. Each comparison uses only the inputs applied in that same cycle. The bench sweeps every operand, amount and code for N = 8, including k = 0 and the unused codes. It then applies the 4-bit reference cases to a second instance built with N = 4.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  // Low two bits of the operation code.
  typedef enum logic [1:0] {
    KIND_LOG  = 2'b00,
    KIND_ARI  = 2'b01,
    KIND_ROT  = 2'b10,
    KIND_NONE = 2'b11
  } fsh_kind_e;

  // Bit 2 of the operation code.
  localparam logic DIR_RIGHT = 1'b0;
  localparam logic DIR_LEFT  = 1'b1;

endpackage

// File: rtl/fsh_zbuild.sv
module fsh_zbuild
  import fsh_pkg::*;
#(
  parameter int N  = 8,
  parameter int KW = $clog2(N),
  parameter int ZW = 2 * N - 1
) (
  input  logic [N-1:0]  a,
  input  logic [KW-1:0] k,
  input  logic [2:0]    op,
  output logic [ZW-1:0] z,
  output logic [KW-1:0] off
);

  fsh_kind_e kind;
  logic      dir;

  assign kind = fsh_kind_e'(op[1:0]);
  assign dir  = op[2];

  always_comb begin
    // The none code lays a in the low half with offset zero, so it passes through.
    z   = {{(N-1){1'b0}}, a};
    off = '0;
    if (kind != KIND_NONE) begin
      if (dir == DIR_RIGHT) begin
        off = k;
        unique case (kind)
          KIND_ARI: z = {{(N-1){a[N-1]}}, a};
          KIND_ROT: z = {a[N-2:0], a};
          default:  z = {{(N-1){1'b0}}, a};
        endcase
      end else begin
        // The inverse of k equals N-1-k, which places the window for a left move.
        off = ~k;
        if (kind == KIND_ROT) z = {a, a[N-1:1]};
        else                  z = {a, {(N-1){1'b0}}};
      end
    end
  end

endmodule

// File: rtl/fsh_window.sv
module fsh_window #(
  parameter int N   = 8,
  parameter int KW  = $clog2(N),
  parameter int ZW  = 2 * N - 1
) (
  input  logic [ZW-1:0] z,
  input  logic [KW-1:0] off,
  output logic [N-1:0]  y
);

  // Ranks run from the largest step down, and each rank drops the bits it can no longer reach.
  for (genvar j = 0; j < KW; j++) begin : g_stage
    localparam int STEP = 1 << j;
    localparam int WOUT = N + STEP - 1;
    localparam int WIN  = N + 2 * STEP - 1;
    logic [WIN-1:0]  win;
    logic [WOUT-1:0] wout;
    if (j == KW - 1) begin : g_first
      assign win = z;
    end else begin : g_next
      assign win = g_stage[j+1].wout;
    end
    assign wout = off[j] ? win[WIN-1:STEP] : win[WOUT-1:0];
  end

  assign y = g_stage[0].wout;

endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel #(
  parameter int N  = 8,
  parameter int KW = $clog2(N)
) (
  input  logic [N-1:0]  a,
  input  logic [KW-1:0] k,
  input  logic [2:0]    op,
  output logic [N-1:0]  y
);

  localparam int ZW = 2 * N - 1;

  logic [ZW-1:0] z;
  logic [KW-1:0] off;

  fsh_zbuild #(.N(N), .KW(KW), .ZW(ZW)) u_zbuild (
    .a   (a),
    .k   (k),
    .op  (op),
    .z   (z),
    .off (off)
  );

  fsh_window #(.N(N), .KW(KW), .ZW(ZW)) u_window (
    .z   (z),
    .off (off),
    .y   (y)
  );

endmodule

// File: rtl/fsh_funnel_chk.sv
module fsh_funnel_chk #(
  parameter int N  = 8,
  parameter int KW = $clog2(N)
) (
  input logic [N-1:0]  a,
  input logic [KW-1:0] k,
  input logic [2:0]    op,
  input logic [N-1:0]  y
);

  always_comb begin
    if (!$isunknown({a, k, op, y})) begin
      // R3
      rot_r_ones_chk: assert (op != 3'b010 || $countones(y) == $countones(a));
      // R6
      rot_l_ones_chk: assert (op != 3'b110 || $countones(y) == $countones(a));
      // R1
      lsr_msb_chk: assert (op != 3'b000 || k == '0 || y[N-1] == 1'b0);
      // R2
      asr_sign_chk: assert (op != 3'b001 || y[N-1] == a[N-1]);
      // R4
      lsl_lsb_chk: assert (op[2] != 1'b1 || op[1] != 1'b0 || k == '0 || y[0] == 1'b0);
      // R7
      none_pass_chk: assert (op[1:0] != 2'b11 || y == a);
      // R8
      zero_amt_chk: assert (k != '0 || y == a);
    end
  end

endmodule

bind fsh_funnel fsh_funnel_chk #(.N(N), .KW(KW)) u_fsh_chk (
  .a  (a),
  .k  (k),
  .op (op),
  .y  (y)
);

// File: tb/fsh_funnel_bench.sv
`timescale 1ns/1ps
module fsh_funnel_bench;

  logic       clk;
  logic [7:0] a8;
  logic [2:0] k8;
  logic [2:0] op8;
  logic [7:0] y8;
  logic [3:0] a4;
  logic [1:0] k4;
  logic [2:0] op4;
  logic [3:0] y4;

  int vecs;
  int errs;
  bit done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  fsh_funnel #(.N(8)) u_fsh_funnel (.a(a8), .k(k8), .op(op8), .y(y8));
  fsh_funnel #(.N(4)) u_fsh_funnel4 (.a(a4), .k(k4), .op(op4), .y(y4));

  function automatic logic [7:0] ref8(input logic [7:0] a, input int k, input logic [2:0] op);
    logic [7:0] r;
    case (op)
      3'b000: r = a >> k;
      3'b001: r = 8'($signed(a) >>> k);
      3'b010: for (int i = 0; i < 8; i++) r[i] = a[(i + k) % 8];
      3'b100, 3'b101: r = a << k;
      3'b110: for (int i = 0; i < 8; i++) r[i] = a[(i - k + 8) % 8];
      default: r = a;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b100: return "R4";
      3'b101: return "R5";
      3'b110: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: a=%h k=%0d op=%b got %h expected %h", req, a8, k8, op8, act, exp);
    end
  endtask

  initial begin
    vecs = 0; errs = 0; done = 0;
    a8 = 8'hB4; k8 = 3'd0; op8 = 3'b000;
    a4 = 4'b1011; k4 = 2'd0; op4 = 3'b000;
    @(negedge clk);
    // R8, initial vector with k = 0
    check("R8", y8, 8'hB4);

    // R1..R7, R10: every operand, amount and code, result due in the same cycle
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 8; k++)
        for (int a = 0; a < 256; a++) begin
          @(posedge clk); #1;
          a8 = 8'(a); k8 = 3'(k); op8 = 3'(op);
          @(negedge clk);
          check(tag(3'(op)), y8, ref8(8'(a), k, 3'(op)));
          if (k == 0) check("R8", y8, 8'(a));
          if (op == 5) check("R5", y8, 8'(a) << k);
          if (op[1:0] == 2'b11) check("R7", y8, 8'(a));
          check("R10", y8, ref8(8'(a), k, 3'(op)));
        end

    // R9: the 4-bit reference cases, a = 1011, k = 1
    for (int op = 0; op < 8; op++) begin
      logic [3:0] e;
      case (op)
        0: e = 4'b0101; 1: e = 4'b1101; 2: e = 4'b1101;
        4: e = 4'b0110; 5: e = 4'b0110; 6: e = 4'b0111;
        default: e = 4'b1011;
      endcase
      @(posedge clk); #1;
      a4 = 4'b1011; k4 = 2'd1; op4 = 3'(op);
      @(negedge clk);
      vecs++;
      if (y4 !== e) begin
        errs++;
        $display("FAIL R9: op=%b got %b expected %b", op4, y4, e);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule